// File: doc/BRIEF.md
# Dual-Mode Serial Network Port Transmitter

This block is the sending half of a serial network port. Bytes arrive on a valid/ready stream, with a last-byte flag that closes the frame. They are serialised least-significant bit first. The bit rate comes from a programmable half-bit divider on the system clock. A static mode input, sampled when a frame begins, selects one of two line formats.

In the encoded mode, the block applies Differential Manchester coding itself. It drives the coded level on the data pin and raises a transmitter-enable pin. That enable rises one bit time before the first cell and falls one bit time after the last cell. In the raw mode, the data pin carries plain NRZ bit values. The enable pin becomes a bit clock, and a third pin gives a frame clock, so that an external transceiver can do its own encoding.

A one-byte holding register sits behind the shift register. A bypass path lets a byte that arrives exactly on a byte boundary go straight into the shifter. Consecutive bytes therefore leave without gaps. If no byte is available at a boundary, the frame closes as though the previous byte had been flagged last.

Top module: `sernet_tx`

## Requirements
- R1: After reset, `line_out`, `aux_out` and `frm_out` are 0 and `in_ready` is 1.
- R2: Each half bit cell lasts `half_div`+1 clock cycles. The first cell boundary comes that many cycles after the accepting clock edge.
- R3: In encoded mode (`mode_raw`=0), every bit cell has a level change at its middle. A cell whose bit is 0 also has a level change at its start, and a cell whose bit is 1 has none there. Bits go out LSB first, and bytes go out in arrival order.
- R4: In encoded mode, `aux_out` is the transmitter enable. It is 1 for exactly one bit time (2 half cells) before the first data cell, for every data cell, and for one bit time after the last cell. It is 0 otherwise. The line holds its level during the lead and trail bit times.
- R5: In raw mode (`mode_raw`=1), `line_out` equals the current bit (LSB first) for the whole cell. `aux_out` is a bit clock that is 0 in the first half and 1 in the second half of each cell, and 0 between frames.
- R6: In raw mode, `frm_out` is 1 exactly while data cells are being sent, with no lead or trail. In encoded mode, `frm_out` stays 0.
- R7: `in_ready` is 1 whenever the port is idle. During the lead and data phases, it is 1 only while the holding register is empty and no last-flagged byte has been taken. After a byte with `in_last`=1 is accepted, `in_ready` stays 0 until the frame ends, including the trail. Bytes of one frame follow each other with no gap cells.
- R8: If no byte is held or offered when the final bit of a byte ends, the frame closes after that byte, exactly as if it had carried `in_last`.
- R9: `mode_raw` and `half_div` are sampled only when a frame's first byte is accepted. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_raw | input | 1 | 0: Differential Manchester with enable; 1: raw NRZ with bit and frame clocks |
| half_div | input | DIV_W | Half-bit period in clock cycles, minus one |
| in_valid | input | 1 | Byte stream valid |
| in_ready | output | 1 | Byte stream ready |
| in_data | input | BYTE_W | Byte to send, LSB first |
| in_last | input | 1 | Marks the final byte of a frame |
| line_out | output | 1 | Serial data pin |
| aux_out | output | 1 | Transmit enable (encoded mode) or bit clock (raw mode) |
| frm_out | output | 1 | Frame clock (raw mode), 0 in encoded mode |

## Verification
Frames are sent in both modes, made of all-zero, all-one, alternating and mixed bytes. All-zero and all-one bytes tell a missing start-of-cell transition apart from a missing mid-cell one, and mixed bytes expose bit-order errors. Dividers from 0 to 3 check the cell length against the accept edge. Multi-byte frames check that the holding register and the bypass keep cells contiguous. Rows that flip the mode and divider mid-frame, and rows that withhold the next byte to force an underrun, cover configuration sampling and early frame closure.

// File: rtl/sernet_pkg.sv
package sernet_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_DATA  = 2'd2,
    ST_TRAIL = 2'd3
  } tx_state_e;
endpackage

// File: rtl/sernet_tick.sv
// Half-bit tick generator: one tick every half_div+1 cycles while running.
module sernet_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sernet_hold.sv
// Single-entry holding register between the stream input and the shifter.
module sernet_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (wr_en) begin
      full <= 1'b1;
      data <= wr_data;
    end else if (rd_en) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/sernet_pins.sv
// Maps the frame state onto the three port pins according to the latched mode.
module sernet_pins
  import sernet_pkg::*;
(
  input  tx_state_e st,
  input  logic      mode_q,
  input  logic      half_q,
  input  logic      bit_now,
  input  logic      dm_level,
  output logic      line_out,
  output logic      aux_out,
  output logic      frm_out
);
  logic in_cells;
  logic active;

  assign in_cells = (st == ST_DATA);
  assign active   = (st != ST_IDLE);

  always_comb begin
    if (mode_q) begin
      line_out = in_cells & bit_now;
      aux_out  = in_cells & half_q;
      frm_out  = in_cells;
    end else begin
      line_out = dm_level;
      aux_out  = active;
      frm_out  = 1'b0;
    end
  end
endmodule

// File: rtl/sernet_tx.sv
module sernet_tx
  import sernet_pkg::*;
#(
  parameter int DIV_W  = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_raw,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_data,
  input  logic              in_last,
  output logic              line_out,
  output logic              aux_out,
  output logic              frm_out
);
  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  tx_state_e         st_q;
  logic              half_q;
  logic [IDX_W-1:0]  idx_q;
  logic [BYTE_W-1:0] sh_q;
  logic              lvl_q;
  logic              closed_q;
  logic              mode_q;
  logic [DIV_W-1:0]  div_q;

  logic              tick;
  logic              accept;
  logic              boundary;
  logic              hold_full;
  logic [BYTE_W-1:0] hold_data;
  logic              bypass;
  logic              have_next;
  logic [BYTE_W-1:0] next_byte;

  assign in_ready = (st_q == ST_IDLE) ||
                    (((st_q == ST_LEAD) || (st_q == ST_DATA)) && !hold_full && !closed_q);
  assign accept    = in_valid && in_ready;
  assign boundary  = tick && (st_q == ST_DATA) && half_q && (idx_q == LAST_IDX);
  assign bypass    = boundary && !hold_full && accept;
  assign have_next = hold_full || bypass;
  assign next_byte = hold_full ? hold_data : in_data;

  sernet_tick #(.DIV_W(DIV_W)) u_tick (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (st_q != ST_IDLE),
    .half_div (div_q),
    .tick     (tick)
  );

  sernet_hold #(.W(BYTE_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (accept && (st_q != ST_IDLE) && !bypass),
    .wr_data (in_data),
    .rd_en   (boundary && hold_full),
    .full    (hold_full),
    .data    (hold_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      half_q   <= 1'b0;
      idx_q    <= '0;
      sh_q     <= '0;
      lvl_q    <= 1'b0;
      closed_q <= 1'b0;
      mode_q   <= 1'b0;
      div_q    <= '0;
    end else begin
      if (accept && in_last) begin
        closed_q <= 1'b1;
      end
      unique case (st_q)
        ST_IDLE: begin
          if (accept) begin
            sh_q     <= in_data;
            closed_q <= in_last;
            mode_q   <= mode_raw;
            div_q    <= half_div;
            half_q   <= 1'b0;
            idx_q    <= '0;
            st_q     <= mode_raw ? ST_DATA : ST_LEAD;
          end
        end
        ST_LEAD: begin
          if (tick) begin
            if (!half_q) begin
              half_q <= 1'b1;
            end else begin
              half_q <= 1'b0;
              st_q   <= ST_DATA;
              lvl_q  <= lvl_q ^ ~sh_q[0];
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (!half_q) begin
              half_q <= 1'b1;
              lvl_q  <= ~lvl_q;
            end else begin
              half_q <= 1'b0;
              if (idx_q != LAST_IDX) begin
                idx_q <= idx_q + 1'b1;
                sh_q  <= sh_q >> 1;
                lvl_q <= lvl_q ^ ~sh_q[1];
              end else if (have_next) begin
                idx_q <= '0;
                sh_q  <= next_byte;
                lvl_q <= lvl_q ^ ~next_byte[0];
              end else begin
                st_q <= mode_q ? ST_IDLE : ST_TRAIL;
              end
            end
          end
        end
        ST_TRAIL: begin
          if (tick) begin
            if (!half_q) begin
              half_q <= 1'b1;
            end else begin
              half_q <= 1'b0;
              st_q   <= ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  sernet_pins u_pins (
    .st       (st_q),
    .mode_q   (mode_q),
    .half_q   (half_q),
    .bit_now  (sh_q[0]),
    .dm_level (lvl_q),
    .line_out (line_out),
    .aux_out  (aux_out),
    .frm_out  (frm_out)
  );
endmodule

// File: rtl/sernet_tx_chk.sv
module sernet_tx_chk
  import sernet_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      in_valid,
  input logic      in_ready,
  input logic      in_last,
  input logic      line_out,
  input logic      aux_out,
  input logic      frm_out,
  input logic      mode_q,
  input logic      tick,
  input logic      half_q,
  input tx_state_e st_q
);
  assert_last_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);

  assert_trail_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_TRAIL) |-> !in_ready);

  assert_bitclk_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && aux_out) |-> frm_out);

  assert_frame_starts_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frm_out) |-> !aux_out);

  assert_mid_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && st_q == ST_DATA && !half_q && tick) |=> !$stable(line_out));

  assert_line_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_q && $past(!mode_q) && !$stable(line_out)) |-> $past(tick));
endmodule

bind sernet_tx sernet_tx_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .in_last  (in_last),
  .line_out (line_out),
  .aux_out  (aux_out),
  .frm_out  (frm_out),
  .mode_q   (mode_q),
  .tick     (tick),
  .half_q   (half_q),
  .st_q     (st_q)
);

// File: tb/test_sernet_tx.sv
`timescale 1ns/1ps
module test_sernet_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_raw = 1'b0;
  logic [7:0] half_div = 8'd0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'd0;
  logic       in_last = 1'b0;
  logic       line_out, aux_out, frm_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int e0 = 0;
  bit started = 0;
  bit done = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sernet_tx #(.DIV_W(8), .BYTE_W(8)) i_sernet_tx (
    .clk(clk), .rst_n(rst_n), .mode_raw(mode_raw), .half_div(half_div),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .line_out(line_out), .aux_out(aux_out), .frm_out(frm_out)
  );

  typedef struct packed {
    logic       mode;
    logic       chg;
    logic       nolast;
    logic [1:0] n;
    logic [7:0] div;
    logic [7:0] b0;
    logic [7:0] b1;
    logic [7:0] b2;
  } row_t;

  localparam int NROWS = 8;
  localparam row_t ROWS [NROWS] = '{
    '{1'b0, 1'b0, 1'b0, 2'd1, 8'd1, 8'hA5, 8'h00, 8'h00},
    '{1'b0, 1'b0, 1'b0, 2'd2, 8'd0, 8'h00, 8'hFF, 8'h00},
    '{1'b1, 1'b0, 1'b0, 2'd3, 8'd2, 8'h3C, 8'h81, 8'h5A},
    '{1'b1, 1'b0, 1'b0, 2'd1, 8'd0, 8'h01, 8'h00, 8'h00},
    '{1'b0, 1'b1, 1'b0, 2'd3, 8'd3, 8'h96, 8'h0F, 8'hE1},
    '{1'b1, 1'b1, 1'b0, 2'd2, 8'd1, 8'hC3, 8'h7E, 8'h00},
    '{1'b0, 1'b0, 1'b1, 2'd1, 8'd2, 8'h6B, 8'h00, 8'h00},
    '{1'b1, 1'b0, 1'b1, 2'd1, 8'd0, 8'hF0, 8'h00, 8'h00}
  };

  task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: {line,aux,frm} actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
    end
  endtask

  task automatic wait_slot(input int target);
    while (cyc < target) @(negedge clk);
  endtask

  task automatic run_row(input row_t r, input int ri);
    int h = int'(r.div) + 1;
    int nb = int'(r.n);
    logic [23:0] stream = {r.b2, r.b1, r.b0};
    started = 0;
    fork
      begin : drive
        @(negedge clk);
        mode_raw = r.mode;
        half_div = r.div;
        for (int i = 0; i < nb; i++) begin
          in_valid = 1'b1;
          in_data  = stream[i*8 +: 8];
          in_last  = (i == nb - 1) && !r.nolast;
          while (!in_ready) @(negedge clk);
          if (i == 0) begin
            e0 = cyc + 1;
            started = 1;
          end
          @(negedge clk);
          if (i == 0 && r.chg) begin
            mode_raw = ~r.mode;
            half_div = r.div + 8'd3;
          end
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        if (!r.nolast) check1($sformatf("R7 row %0d ready low after last", ri), in_ready, 1'b0);
      end
      begin : watch
        logic l;
        string rq;
        wait (started);
        if (!r.mode) begin
          rq = r.chg ? "R9/R4" : "R4";
          wait_slot(e0);
          l = line_out;
          check({rq, " lead"}, {line_out, aux_out, frm_out}, {l, 2'b10});
          wait_slot(e0 + h);
          check({rq, " lead"}, {line_out, aux_out, frm_out}, {l, 2'b10});
          for (int j = 0; j < nb * 8; j++) begin
            if (!stream[j]) l = ~l;
            wait_slot(e0 + (2 + 2*j) * h);
            check(r.chg ? "R9/R3 start" : "R3/R2 start", {line_out, aux_out, frm_out}, {l, 2'b10});
            l = ~l;
            wait_slot(e0 + (3 + 2*j) * h);
            check(r.chg ? "R9/R3 mid" : "R3/R2 mid", {line_out, aux_out, frm_out}, {l, 2'b10});
          end
          wait_slot(e0 + (2 + 16*nb) * h);
          check(r.nolast ? "R8 trail" : "R4 trail", {line_out, aux_out, frm_out}, {l, 2'b10});
          wait_slot(e0 + (3 + 16*nb) * h);
          check(r.nolast ? "R8 trail" : "R4 trail", {line_out, aux_out, frm_out}, {l, 2'b10});
          wait_slot(e0 + (4 + 16*nb) * h);
          check1(r.nolast ? "R8 enable off" : "R4 enable off", aux_out, 1'b0);
        end else begin
          rq = r.chg ? "R9/R5" : "R5/R6";
          for (int j = 0; j < nb * 8; j++) begin
            wait_slot(e0 + (2*j) * h);
            check({rq, " first half"}, {line_out, aux_out, frm_out}, {stream[j], 2'b01});
            wait_slot(e0 + (2*j + 1) * h);
            check({rq, " second half"}, {line_out, aux_out, frm_out}, {stream[j], 2'b11});
          end
          wait_slot(e0 + 16*nb*h);
          check(r.nolast ? "R8 raw end" : "R6 raw end", {line_out, aux_out, frm_out}, 3'b000);
        end
      end
    join
    repeat (2) @(negedge clk);
    check1($sformatf("R7 row %0d ready when idle", ri), in_ready, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {line_out, aux_out, frm_out}, 3'b000);
    check1("R1 reset ready", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {line_out, aux_out, frm_out}, 3'b000);
    for (int ri = 0; ri < NROWS; ri++) begin
      run_row(ROWS[ri], ri);
    end
    // R7: valid held with no frame open is taken at once; after it, a byte offered while closed waits
    @(negedge clk);
    mode_raw = 1'b1;
    half_div = 8'd0;
    in_valid = 1'b1;
    in_data  = 8'h55;
    in_last  = 1'b1;
    @(negedge clk);
    in_data = 8'hAA;
    in_last = 1'b0;
    check1("R7 closed frame refuses second byte", in_ready, 1'b0);
    repeat (15) @(negedge clk);
    check1("R7 still closed on final cell", in_ready, 1'b0);
    @(negedge clk);
    check1("R7 ready again after frame", in_ready, 1'b1);
    in_valid = 1'b0;
    repeat (40) @(negedge clk);
    check("R6 idle after raw frames", {line_out, aux_out, frm_out}, 3'b000);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule